// File: doc/BRIEF.md
# Clock Root Configuration Register Bank

This block is the programming front end of a clock root generator. Software writes the divider settings into a set of staged registers: the pre-divider, the source select, the M/N mode, a hardware clock-control bit and the M, N and D values. None of these values reaches the divider datapath at once. Software then sets the update bit in the command register. The block waits until the datapath reports a stable clock, and then copies every staged value into the active registers in one cycle. The update bit then reads back as 0, which tells software that the new setting is in force.

The command register also has a force-enable bit, which keeps the root requested while it is reconfigured. It has a read-only root-off status bit and four read-only flags that show which staged registers differ from the active setting. The datapath receives a root request and the active fields. The dividers and the source multiplexer sit outside this block.

Top module: `clk_root_cfg_bank`

## Requirements
- R1: After reset, every staged and active field is 0, the update and force-enable bits are 0, all change flags are 0, root_req is 0 and the command register reads 0x8000_0000 (root off).
- R2: A write to offset 0x4, 0x8, 0xC or 0x10 stores the value, and it reads back at the same offset. At 0x4 only these fields exist: pre-divider [PD_W-1:0], source [10:8], mode [13:12] and hardware control [20]. At 0x8, 0xC and 0x10 only [MND_W-1:0] exists. All other bits read 0. The active outputs do not change on these writes.
- R3: Writing a word with bit 0 set to offset 0x0 sets the pending update (bit 0 reads 1) on the next edge. On the first edge at which the update is pending and clk_stable is high, all active outputs take the staged values, and bit 0 reads 0 after that edge.
- R4: While clk_stable is low, a pending update stays pending and the active outputs hold. Writing 0 to bit 0 does not cancel the update.
- R5: Command bits 4, 5, 6 and 7 flag the configuration register, N, M and D. A flag is set by a write whose stored value differs from the active value. It stays set until the next commit, which clears it. A write equal to the active value leaves the flag clear.
- R6: The flags (bits 7:4) and root-off (bit 31) are read-only. Writing 1s to them changes nothing.
- R7: Command bit 1 is a read/write force-enable. The root_req output is high whenever force-enable is set or an update is pending.
- R8: Command bit 31 (root off) reads 0 one edge after an edge at which root_req and clk_stable were both high. Otherwise it reads 1.
- R9: Reads of any other offset return 0, and writes to one change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| clk_stable | input | 1 | Datapath reports a stable root clock |
| root_req | output | 1 | Request to run the root clock |
| act_pre_div | output | PD_W | Active pre-divider |
| act_src_sel | output | 3 | Active source select |
| act_mode | output | 2 | Active mode (0 bypass, 2 dual-edge M/N) |
| act_hw_ctl | output | 1 | Active hardware clock-control bit |
| act_m | output | MND_W | Active M value |
| act_n | output | MND_W | Active N value |
| act_d | output | MND_W | Active D value |

## Verification
A fault in the commit state shows up in one of two ways. The update bit can stay set after the first stable cycle. The active outputs can also move before a commit, or fail to move on it. Either is visible on the edge after the update is armed. A fault in the change flags shows at the next read of the command register, and the bench reads it between writes and commits. A fault in the root tracking shows in bit 31 one edge after root_req or clk_stable changes.

// File: rtl/clkroot_pkg.sv
// Package: register offsets, bit positions and change-flag indices
// shared by the clock root configuration bank.
package clkroot_pkg;
    localparam int ADDR_W        = 5;
    localparam logic [ADDR_W-1:0] OFS_CMD = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CFG = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_M   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_N   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_D   = 5'h10;

    localparam int BIT_UPD       = 0;
    localparam int BIT_FORCE     = 1;
    localparam int FLAG_LSB      = 4;
    localparam int BIT_OFF       = 31;
    localparam int SRC_LSB       = 8;
    localparam int SRC_W         = 3;
    localparam int MODE_LSB      = 12;
    localparam int MODE_W        = 2;
    localparam int HWC_BIT       = 20;
    localparam int NUM_MND       = 3;   // 0: M, 1: N, 2: D
    localparam int NUM_FLAGS     = 4;

    // Flag order in the command register is fixed: CFG, N, M, D.
    typedef enum logic [1:0] {
        FL_CFG = 2'd0,
        FL_N   = 2'd1,
        FL_M   = 2'd2,
        FL_D   = 2'd3
    } flag_idx_e;

    // Maps an M/N/D slot to its change-flag position.
    function automatic flag_idx_e mnd_flag(input int slot);
        case (slot)
            0:       return FL_M;
            1:       return FL_N;
            default: return FL_D;
        endcase
    endfunction

    // Byte offset of an M/N/D slot.
    function automatic logic [ADDR_W-1:0] mnd_ofs(input int slot);
        case (slot)
            0:       return OFS_M;
            1:       return OFS_N;
            default: return OFS_D;
        endcase
    endfunction
endpackage

// File: rtl/clkroot_stage.sv
// Staged register file. It decodes bus writes to the configuration
// register and the three M/N/D registers and stores the masked fields.
// It also presents the incoming field values and per-register write hits,
// so that the commit logic can judge changes.
// Assumes: one write per strobe cycle, word-aligned byte offsets.
module clkroot_stage
    import clkroot_pkg::*;
#(
    parameter int PD_W  = 5,
    parameter int MND_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [31:0]                      wr_data,
    output logic                             hit_cfg,
    output logic [NUM_MND-1:0]               hit_mnd,
    output logic [PD_W-1:0]                  in_pre,
    output logic [SRC_W-1:0]                 in_src,
    output logic [MODE_W-1:0]                in_mode,
    output logic                             in_hwc,
    output logic [MND_W-1:0]                 in_mnd,
    output logic [PD_W-1:0]                  stg_pre,
    output logic [SRC_W-1:0]                 stg_src,
    output logic [MODE_W-1:0]                stg_mode,
    output logic                             stg_hwc,
    output logic [NUM_MND-1:0][MND_W-1:0]    stg_mnd
);
    // Field extraction from the write word.
    always_comb begin
        in_pre  = wr_data[PD_W-1:0];
        in_src  = wr_data[SRC_LSB +: SRC_W];
        in_mode = wr_data[MODE_LSB +: MODE_W];
        in_hwc  = wr_data[HWC_BIT];
        in_mnd  = wr_data[MND_W-1:0];
        hit_cfg = wr_en && (wr_addr == OFS_CFG);
    end

    // Configuration register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_pre  <= '0;
            stg_src  <= '0;
            stg_mode <= '0;
            stg_hwc  <= 1'b0;
        end else if (hit_cfg) begin
            stg_pre  <= in_pre;
            stg_src  <= in_src;
            stg_mode <= in_mode;
            stg_hwc  <= in_hwc;
        end
    end

    // One storage slot per M/N/D register.
    for (genvar s = 0; s < NUM_MND; s++) begin : g_mnd
        assign hit_mnd[s] = wr_en && (wr_addr == mnd_ofs(s));

        // Slot storage.
        always_ff @(posedge clk) begin
            if (!rst_n)          stg_mnd[s] <= '0;
            else if (hit_mnd[s]) stg_mnd[s] <= in_mnd;
        end
    end

    // R2: staged values move only on a write strobe.
    a_r2_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({stg_pre, stg_src, stg_mode, stg_hwc, stg_mnd}));
endmodule

// File: rtl/clkroot_commit.sv
// Update handshake and active register set. An update request arms a
// pending flag. The first cycle with clk_stable high copies all staged
// fields to the active set and drops the pending flag. Change flags mark
// staged registers written with values that differ from the active
// setting, and a commit clears them.
// Assumes: clk_stable is synchronous to clk.
module clkroot_commit
    import clkroot_pkg::*;
#(
    parameter int PD_W  = 5,
    parameter int MND_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             upd_set,
    input  logic                             clk_stable,
    input  logic                             hit_cfg,
    input  logic [NUM_MND-1:0]               hit_mnd,
    input  logic [PD_W-1:0]                  in_pre,
    input  logic [SRC_W-1:0]                 in_src,
    input  logic [MODE_W-1:0]                in_mode,
    input  logic                             in_hwc,
    input  logic [MND_W-1:0]                 in_mnd,
    input  logic [PD_W-1:0]                  stg_pre,
    input  logic [SRC_W-1:0]                 stg_src,
    input  logic [MODE_W-1:0]                stg_mode,
    input  logic                             stg_hwc,
    input  logic [NUM_MND-1:0][MND_W-1:0]    stg_mnd,
    output logic                             upd_pend,
    output logic [NUM_FLAGS-1:0]             flags,
    output logic [PD_W-1:0]                  act_pre,
    output logic [SRC_W-1:0]                 act_src,
    output logic [MODE_W-1:0]                act_mode,
    output logic                             act_hwc,
    output logic [NUM_MND-1:0][MND_W-1:0]    act_mnd
);
    localparam int CFG_W = PD_W + SRC_W + MODE_W + 1;

    logic                          commit;
    logic [CFG_W-1:0]              cfg_after;
    logic [NUM_MND-1:0][MND_W-1:0] mnd_after;
    logic [NUM_FLAGS-1:0]          flags_nxt;

    assign commit = upd_pend && clk_stable;

    // Active values as they stand after this edge, used to judge changes.
    always_comb begin
        cfg_after = commit ? {stg_pre, stg_src, stg_mode, stg_hwc}
                           : {act_pre, act_src, act_mode, act_hwc};
        mnd_after = commit ? stg_mnd : act_mnd;
    end

    // Next change-flag state: cleared by commit, set by differing writes.
    always_comb begin
        flags_nxt = commit ? '0 : flags;
        if (hit_cfg && ({in_pre, in_src, in_mode, in_hwc} != cfg_after))
            flags_nxt[FL_CFG] = 1'b1;
        for (int s = 0; s < NUM_MND; s++)
            if (hit_mnd[s] && (in_mnd != mnd_after[s]))
                flags_nxt[mnd_flag(s)] = 1'b1;
    end

    // Pending-update flag: a new request wins, a commit clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_pend <= 1'b0;
        else        upd_pend <= upd_set || (upd_pend && !clk_stable);
    end

    // Change-flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nxt;
    end

    // Active register set, loaded as a whole on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pre  <= '0;
            act_src  <= '0;
            act_mode <= '0;
            act_hwc  <= 1'b0;
            act_mnd  <= '0;
        end else if (commit) begin
            act_pre  <= stg_pre;
            act_src  <= stg_src;
            act_mode <= stg_mode;
            act_hwc  <= stg_hwc;
            act_mnd  <= stg_mnd;
        end
    end

    // R3: a stable clock completes a pending update on the next edge.
    a_r3_update_done: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pend && clk_stable && !upd_set |=> !upd_pend);

    // R4: no stable clock means the active set holds and the request stays.
    a_r4_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pend && !clk_stable |=> upd_pend &&
        $stable({act_pre, act_src, act_mode, act_hwc, act_mnd}));

    // R5: a commit with no coincident staged write leaves no flag set.
    a_r5_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pend && clk_stable && !hit_cfg && (hit_mnd == '0) |=> (flags == '0));
endmodule

// File: rtl/clkroot_status.sv
// Root control: it holds the force-enable bit, drives the root request
// and tracks whether the root is running. The root counts as running
// once the request and clk_stable have both been high at an edge.
// Assumes: cmd_wr is a single-cycle write to the command register.
module clkroot_status (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic force_val,
    input  logic upd_pend,
    input  logic clk_stable,
    output logic force_en,
    output logic root_req,
    output logic root_off
);
    logic root_on_q;

    assign root_req = force_en || upd_pend;
    assign root_off = !root_on_q;

    // Force-enable bit, written through the command register.
    always_ff @(posedge clk) begin
        if (!rst_n)      force_en <= 1'b0;
        else if (cmd_wr) force_en <= force_val;
    end

    // Running indicator.
    always_ff @(posedge clk) begin
        if (!rst_n) root_on_q <= 1'b0;
        else        root_on_q <= root_req && clk_stable;
    end

    // R8: no request means the root reads off after the next edge.
    a_r8_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !root_req |=> root_off);

    // R8: a request with a stable clock reads as running after the next edge.
    a_r8_on_when_stable: assert property (@(posedge clk) disable iff (!rst_n)
        root_req && clk_stable |=> !root_off);
endmodule

// File: rtl/clk_root_cfg_bank.sv
// Top of the clock root configuration bank. It joins the staged register
// file, the commit handshake and the root control, and provides the
// combinational read mux of the register window.
// Assumes: bus_addr is a word-aligned byte offset, and reads have no side effect.
module clk_root_cfg_bank
    import clkroot_pkg::*;
#(
    parameter int PD_W  = 5,
    parameter int MND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              clk_stable,
    output logic              root_req,
    output logic [PD_W-1:0]   act_pre_div,
    output logic [2:0]        act_src_sel,
    output logic [1:0]        act_mode,
    output logic              act_hw_ctl,
    output logic [MND_W-1:0]  act_m,
    output logic [MND_W-1:0]  act_n,
    output logic [MND_W-1:0]  act_d
);
    logic                          cmd_wr, upd_set, upd_pend, force_en, root_off;
    logic                          hit_cfg;
    logic [NUM_MND-1:0]            hit_mnd;
    logic [PD_W-1:0]               in_pre, stg_pre;
    logic [SRC_W-1:0]              in_src, stg_src;
    logic [MODE_W-1:0]             in_mode, stg_mode;
    logic                          in_hwc, stg_hwc;
    logic [MND_W-1:0]              in_mnd;
    logic [NUM_MND-1:0][MND_W-1:0] stg_mnd, act_mnd;
    logic [NUM_FLAGS-1:0]          flags;

    assign cmd_wr  = bus_we && (bus_addr == OFS_CMD);
    assign upd_set = cmd_wr && bus_wdata[BIT_UPD];

    clkroot_stage #(.PD_W(PD_W), .MND_W(MND_W)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
        .hit_cfg(hit_cfg), .hit_mnd(hit_mnd),
        .in_pre(in_pre), .in_src(in_src), .in_mode(in_mode), .in_hwc(in_hwc),
        .in_mnd(in_mnd),
        .stg_pre(stg_pre), .stg_src(stg_src), .stg_mode(stg_mode),
        .stg_hwc(stg_hwc), .stg_mnd(stg_mnd)
    );

    clkroot_commit #(.PD_W(PD_W), .MND_W(MND_W)) u_commit (
        .clk(clk), .rst_n(rst_n),
        .upd_set(upd_set), .clk_stable(clk_stable),
        .hit_cfg(hit_cfg), .hit_mnd(hit_mnd),
        .in_pre(in_pre), .in_src(in_src), .in_mode(in_mode), .in_hwc(in_hwc),
        .in_mnd(in_mnd),
        .stg_pre(stg_pre), .stg_src(stg_src), .stg_mode(stg_mode),
        .stg_hwc(stg_hwc), .stg_mnd(stg_mnd),
        .upd_pend(upd_pend), .flags(flags),
        .act_pre(act_pre_div), .act_src(act_src_sel), .act_mode(act_mode),
        .act_hwc(act_hw_ctl), .act_mnd(act_mnd)
    );

    clkroot_status u_status (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .force_val(bus_wdata[BIT_FORCE]),
        .upd_pend(upd_pend), .clk_stable(clk_stable),
        .force_en(force_en), .root_req(root_req), .root_off(root_off)
    );

    assign act_m = act_mnd[0];
    assign act_n = act_mnd[1];
    assign act_d = act_mnd[2];

    // Read mux over the register window.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CMD: begin
                bus_rdata[BIT_UPD]                   = upd_pend;
                bus_rdata[BIT_FORCE]                 = force_en;
                bus_rdata[FLAG_LSB +: NUM_FLAGS]     = flags;
                bus_rdata[BIT_OFF]                   = root_off;
            end
            OFS_CFG: begin
                bus_rdata[PD_W-1:0]                  = stg_pre;
                bus_rdata[SRC_LSB +: SRC_W]          = stg_src;
                bus_rdata[MODE_LSB +: MODE_W]        = stg_mode;
                bus_rdata[HWC_BIT]                   = stg_hwc;
            end
            OFS_M:   bus_rdata[MND_W-1:0] = stg_mnd[0];
            OFS_N:   bus_rdata[MND_W-1:0] = stg_mnd[1];
            OFS_D:   bus_rdata[MND_W-1:0] = stg_mnd[2];
            default: bus_rdata = '0;
        endcase
    end

    // R7: an armed update always requests the root.
    a_r7_req_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pend |-> root_req);

    // R7: a write that sets force-enable raises the request on the next edge.
    a_r7_force_req: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && bus_wdata[BIT_FORCE] |=> root_req);
endmodule

// File: tb/clk_root_cfg_bank_test.sv
module clk_root_cfg_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clk_stable = 1'b0;
    logic        root_req;
    logic [4:0]  act_pre_div;
    logic [2:0]  act_src_sel;
    logic [1:0]  act_mode;
    logic        act_hw_ctl;
    logic [7:0]  act_m, act_n, act_d;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    clk_root_cfg_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_stable(clk_stable),
        .root_req(root_req), .act_pre_div(act_pre_div), .act_src_sel(act_src_sel),
        .act_mode(act_mode), .act_hw_ctl(act_hw_ctl),
        .act_m(act_m), .act_n(act_n), .act_d(act_d)
    );

    typedef struct packed {
        logic [4:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expect_rd;
    } vec_t;

    // Write, then read back at the same offset.
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{5'h04, 32'hFFFF_FFFF, 32'h0010_371F},  // R2 all CFG fields
        '{5'h04, 32'h0000_2305, 32'h0000_2305},  // R2 pre 5, src 3, mode 2
        '{5'h08, 32'h0000_1234, 32'h0000_0034},  // R2 M masked
        '{5'h0C, 32'hFFFF_FFF0, 32'h0000_00F0},  // R2 N masked
        '{5'h10, 32'h0000_00AB, 32'h0000_00AB},  // R2 D
        '{5'h14, 32'hFFFF_FFFF, 32'h0000_0000},  // R9 unmapped
        '{5'h18, 32'h1234_5678, 32'h0000_0000},  // R9 unmapped
        '{5'h04, 32'h0000_2305, 32'h0000_2305}   // R2/R9 CFG unchanged
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(5'h00, rd); check("R1 cmd", rd, 32'h8000_0000);
        bus_read(5'h04, rd); check("R1 cfg", rd, 32'h0);
        check("R1 outputs", {19'b0, act_pre_div, act_src_sel, act_mode, act_hw_ctl},
              32'h0);
        check("R1 mnd", {7'b0, root_req, act_m, act_n, act_d}, 32'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            bus_write(VECS[i].addr, VECS[i].wdata);
            bus_read(VECS[i].addr, rd);
            check($sformatf("R2/R9 vec%0d", i), rd, VECS[i].expect_rd);
        end
        check("R2 active untouched", {act_m, act_n, act_d, 3'b0, act_src_sel, act_mode, act_hw_ctl, act_pre_div},
              32'h0);
        bus_read(5'h00, rd); check("R5 all flags set", rd, 32'h8000_00F0);

        // R4 update held while clock unstable
        bus_write(5'h00, 32'h1);
        bus_read(5'h00, rd); check("R4 pending", rd, 32'h8000_00F1);
        check("R7 req on pending", {31'b0, root_req}, 32'h1);
        repeat (10) @(negedge clk);
        bus_read(5'h00, rd); check("R4 still pending", rd, 32'h8000_00F1);
        check("R4 active held", {24'b0, act_m}, 32'h0);
        bus_write(5'h00, 32'h0);
        bus_read(5'h00, rd); check("R4 no cancel", rd, 32'h8000_00F1);
        bus_write(5'h00, 32'h8000_00F0);
        bus_read(5'h00, rd); check("R6 read-only bits", rd, 32'h8000_00F1);

        // R3 commit on stable clock
        clk_stable = 1'b1;
        @(negedge clk);
        bus_read(5'h00, rd); check("R3 update done", rd, 32'h0000_0000);
        check("R3 active cfg", {24'b0, act_hw_ctl, act_mode, act_src_sel, act_pre_div[1:0]},
              {24'b0, 1'b0, 2'd2, 3'd3, 2'd1});
        check("R3 pre div", {27'b0, act_pre_div}, 32'h5);
        check("R3 active mnd", {8'b0, act_m, act_n, act_d}, 32'h0034_F0AB);
        @(negedge clk);
        bus_read(5'h00, rd); check("R8 root off after request drops", rd, 32'h8000_0000);

        // R5 same value leaves flag clear; differing value sticky
        bus_write(5'h08, 32'h34);
        bus_read(5'h00, rd); check("R5 equal write no flag", rd, 32'h8000_0000);
        bus_write(5'h0C, 32'h11);
        bus_write(5'h0C, 32'hF0);
        bus_read(5'h00, rd); check("R5 N flag sticky", rd, 32'h8000_0020);
        bus_write(5'h00, 32'h1);
        @(negedge clk);
        bus_read(5'h00, rd); check("R5 commit clears flags", rd, 32'h0000_0000);
        check("R5 N committed", {24'b0, act_n}, 32'hF0);

        // R7 / R8 force-enable and root status
        bus_write(5'h00, 32'h2);
        check("R7 force req", {31'b0, root_req}, 32'h1);
        bus_read(5'h00, rd); check("R8 not yet on", rd, 32'h8000_0002);
        @(negedge clk);
        bus_read(5'h00, rd); check("R8 running", rd, 32'h0000_0002);
        clk_stable = 1'b0;
        @(negedge clk);
        bus_read(5'h00, rd); check("R8 off when unstable", rd, 32'h8000_0002);
        bus_write(5'h00, 32'h0);
        check("R7 force cleared", {31'b0, root_req}, 32'h0);

        done = 1'b1;
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end
endmodule